// File: doc/BRIEF.md
# I2C Master Transfer-Count Controller

This block is the register-level byte manager of an I2C master. Software reaches it through a small word-addressed register bus. It loads transmit bytes into a shared 16-byte FIFO, or drains received bytes from that FIFO. It programs a receive byte count and sets the direction, addressing width and bus-hold policy in a control word. Writing the target address register launches a transfer. A byte-level engine does the actual bus signalling and sits outside this block. Each byte is exchanged with that engine through a request/done handshake. The handshake carries two per-byte hints: whether the byte ends with a STOP, and whether the master must NACK it.

The receive count decides when the master NACKs. This happens on the last counted byte, even while the hold bit is set. The hold bit only decides whether the bus is released after the final byte. With hold set, the bus stays owned, so software can refill the FIFO or issue a repeated start with another address write. When the block is transmitting, the count register reads back how many bytes are queued. Events are gathered in a write-one-to-clear interrupt status word. A mask is set and cleared through separate write addresses, and a single registered interrupt line drives out the masked result.

Top module: `i2cm_xfer_ctl`

Register word addresses: 0 control, 1 status, 2 target address, 3 data, 4 count, 5 interrupt status, 6 interrupt enable (reads back the mask), 7 interrupt disable. Control bits: 0 receive (1) / transmit (0), 1 master, 2 normal 7-bit addressing (0 selects 10-bit), 3 ACK enable, 4 hold, 6 FIFO flush (self-clearing, reads 0). Status bits: 5 receive data valid, 8 bus active. Interrupt bits: 0 complete, 1 data threshold, 2 NACK from target, 3 timeout, 4 slave ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.

## Requirements
- R1: After reset, the control, status, count, interrupt status and mask read as 0, and `irq` is low.
- R2: A write to address 2 while control bit 1 is set pulses `eng_start` for one cycle, starting the cycle after the write. `eng_addr` then carries the written value masked to bits [6:0] when control bit 2 is set, or bits [9:0] when it is clear. With control bit 1 clear, the write starts nothing.
- R3: In transmit mode, queued bytes reach `eng_txd` in write order. Address 4 reads the number of queued bytes. When the queue empties with hold clear, the last byte carries `eng_stop`, interrupt bit 0 sets and status bit 8 falls.
- R4: A data write in transmit mode while 16 bytes are queued is dropped, the count stays 16, and interrupt bit 6 sets.
- R5: In receive mode, address 4 reads the remaining byte count, which drops by one per received byte. The byte taken when the count is 1 is flagged with `eng_nack`, whatever the hold bit says. Its completion sets interrupt bit 0.
- R6: Interrupt bit 1 sets when a received byte raises the FIFO fill to 14.
- R7: Status bit 5 is set while received data waits. A data read pops bytes in arrival order, and a read of an empty FIFO returns 0 and sets interrupt bit 7.
- R8: With hold set, status bit 8 stays set after the final byte and `eng_stop` is low on that byte. Clearing hold with nothing pending drops status bit 8.
- R9: Writing 1s to address 5 clears only those interrupt bits. An event in the same cycle wins over the clear.
- R10: Writes to address 6 set mask bits and writes to address 7 clear them. `irq` is the OR of status AND mask, registered one cycle after the status and mask.
- R11: Writing control bit 6 empties the FIFO, and the bit reads back as 0.
- R12: A byte completed with `eng_snack` high sets interrupt bit 2, releases the bus (status bit 8 falls) and does not set bit 0.
- R13: Register read data appears on `bus_rdata` the cycle after `bus_rd` is sampled. The receiving FIFO stalls (no `eng_req`) while 16 bytes are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 10 | Register write data |
| bus_rdata | output | 10 | Registered read data |
| irq | output | 1 | Masked interrupt, registered |
| eng_start | output | 1 | One-cycle start/repeated-start request to the byte engine |
| eng_addr | output | 10 | Target address for the start |
| eng_ten | output | 1 | 10-bit addressing for this start |
| eng_rx | output | 1 | Direction: 1 receive, 0 transmit |
| eng_req | output | 1 | A byte is wanted |
| eng_txd | output | 8 | Byte to transmit |
| eng_stop | output | 1 | Release the bus after this byte |
| eng_nack | output | 1 | Master NACKs this received byte |
| eng_done | input | 1 | Byte handshake complete (valid with `eng_req`) |
| eng_rxd | input | 8 | Received byte, valid with `eng_done` |
| eng_snack | input | 1 | Target NACKed this byte, valid with `eng_done` |

## Verification
Four results have fixed latencies. A register read returns its data one clock after the strobe is sampled. `eng_start` and the new `eng_addr` appear the cycle after the address write. An interrupt status bit sets at the clock that samples its event. `irq` follows one clock after a status or mask change. The bench drives every strobe for exactly one clock between falling edges and samples on the next falling edge, which is where each of these is due. It also checks that `irq` is still low one falling edge earlier. Byte traffic depends on the engine model, which answers each request one clock later. So transfer outcomes are read only after a fixed settling window that is longer than the number of bytes times two clocks.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int REGW = 10;
  localparam int NIRQ = 10;

  localparam logic [3:0] RA_CTRL   = 4'd0;
  localparam logic [3:0] RA_STAT   = 4'd1;
  localparam logic [3:0] RA_TARGET = 4'd2;
  localparam logic [3:0] RA_DATA   = 4'd3;
  localparam logic [3:0] RA_COUNT  = 4'd4;
  localparam logic [3:0] RA_ISTAT  = 4'd5;
  localparam logic [3:0] RA_IEN    = 4'd6;
  localparam logic [3:0] RA_IDIS   = 4'd7;

  localparam int CB_RX     = 0;
  localparam int CB_MASTER = 1;
  localparam int CB_NORMAL = 2;
  localparam int CB_ACK    = 3;
  localparam int CB_HOLD   = 4;
  localparam int CB_FLUSH  = 6;

  localparam int IB_COMP = 0;
  localparam int IB_DATA = 1;
  localparam int IB_NACK = 2;
  localparam int IB_TMO  = 3;
  localparam int IB_SRDY = 4;
  localparam int IB_ROVF = 5;
  localparam int IB_TOVF = 6;
  localparam int IB_RUNF = 7;
  localparam int IB_ARB  = 9;

  localparam int SB_RXV = 5;
  localparam int SB_ACT = 8;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          ovf,
  output logic          unf
);
  // DEPTH must be a power of two: pointers wrap naturally.
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign ovf     = push && full;
  assign unf     = pop && empty;
  assign head    = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_full_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> full);
endmodule

// File: rtl/i2cm_irq.sv
module i2cm_irq #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic         clr_wr,
  input  logic         en_wr,
  input  logic         dis_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~(clr_wr ? wdata : '0)) | set_ev;
      if (en_wr)       mask <= mask | wdata;
      else if (dis_wr) mask <= mask & ~wdata;
      irq <= |(status & mask);
    end
  end

  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && wdata[0] && !set_ev[0]) |=> !status[0]);
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_ev[1] |=> status[1]);
  assert_enable_sets_R10: assert property (@(posedge clk) disable iff (rst)
    (en_wr && wdata[2]) |=> mask[2]);
  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq);
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq #(
  parameter int CNTW = 8,
  parameter int FCW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            launch,
  input  logic            rx,
  input  logic            hold,
  input  logic            host_push,
  input  logic            fifo_empty,
  input  logic            fifo_full,
  input  logic [FCW-1:0]  fifo_cnt,
  input  logic            cnt_wr,
  input  logic [CNTW-1:0] cnt_wdata,
  input  logic            eng_done,
  input  logic            eng_snack,
  output logic            active,
  output logic [CNTW-1:0] rx_left,
  output logic            eng_req,
  output logic            eng_stop,
  output logic            eng_nack,
  output logic            byte_ok,
  output logic            comp_ev,
  output logic            nack_ev
);
  logic last, idle;

  assign last = rx ? (rx_left == CNTW'(1))
                   : ((fifo_cnt == FCW'(1)) && !host_push);
  assign idle = rx ? (rx_left == '0) : fifo_empty;

  assign eng_req  = active && !launch &&
                    (rx ? ((rx_left != '0) && !fifo_full) : !fifo_empty);
  assign eng_stop = last && !hold;
  assign eng_nack = rx && (rx_left == CNTW'(1));
  assign byte_ok  = eng_done && eng_req;
  assign comp_ev  = byte_ok && !eng_snack && last;
  assign nack_ev  = byte_ok && eng_snack;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rx_left <= '0;
    end else begin
      if (cnt_wr) rx_left <= cnt_wdata;
      if (start) begin
        active <= 1'b1;
      end else if (byte_ok) begin
        if (eng_snack) begin
          active <= 1'b0;
        end else begin
          if (rx) rx_left <= rx_left - 1'b1;
          if (last && !hold) active <= 1'b0;
        end
      end else if (active && !hold && idle && !launch) begin
        active <= 1'b0;
      end
    end
  end

  assert_count_steps_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_ok && rx && !eng_snack) |=> (rx_left == $past(rx_left) - 1'b1));
  assert_hold_keeps_bus_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_ok && last && hold && !eng_snack && !start) |=> active);
  assert_release_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    (byte_ok && last && !hold && !start) |=> !active);
  assert_stall_when_full_R13: assert property (@(posedge clk) disable iff (rst)
    (rx && fifo_full) |-> !eng_req);
endmodule

// File: rtl/i2cm_xfer_ctl.sv
module i2cm_xfer_ctl import i2cm_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CNTW = 8,
  localparam int FCW = $clog2(DEPTH) + 1,
  localparam int DATA_LVL = DEPTH - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [3:0]      bus_addr,
  input  logic [REGW-1:0] bus_wdata,
  output logic [REGW-1:0] bus_rdata,
  output logic            irq,
  output logic            eng_start,
  output logic [9:0]      eng_addr,
  output logic            eng_ten,
  output logic            eng_rx,
  output logic            eng_req,
  output logic [7:0]      eng_txd,
  output logic            eng_stop,
  output logic            eng_nack,
  input  logic            eng_done,
  input  logic [7:0]      eng_rxd,
  input  logic            eng_snack
);
  logic [4:0]      ctrl_q;
  logic [9:0]      tgt_q;
  logic            rx, hold;
  logic            wr_ctrl, wr_tgt, wr_data, rd_data, flush, start;
  logic            host_push, host_pop, rx_push, fifo_push, fifo_pop;
  logic [7:0]      fifo_wdata, fifo_head;
  logic [FCW-1:0]  fifo_cnt;
  logic            fifo_empty, fifo_full, fifo_ovf, fifo_unf;
  logic            active, byte_ok, comp_ev, nack_ev, data_ev;
  logic [CNTW-1:0] rx_left;
  logic [NIRQ-1:0] set_ev, istat, imask;

  assign rx      = ctrl_q[CB_RX];
  assign hold    = ctrl_q[CB_HOLD];
  assign eng_rx  = rx;
  assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
  assign wr_tgt  = bus_wr && (bus_addr == RA_TARGET);
  assign wr_data = bus_wr && (bus_addr == RA_DATA);
  assign rd_data = bus_rd && (bus_addr == RA_DATA);
  assign flush   = wr_ctrl && bus_wdata[CB_FLUSH];
  assign start   = wr_tgt && ctrl_q[CB_MASTER];

  assign host_push  = wr_data && !rx;
  assign host_pop   = rd_data && rx;
  assign rx_push    = byte_ok && rx && !eng_snack;
  assign fifo_push  = host_push || rx_push;
  assign fifo_pop   = host_pop || (byte_ok && !rx);
  assign fifo_wdata = rx ? eng_rxd : bus_wdata[7:0];
  assign eng_txd    = fifo_head;
  assign data_ev    = rx_push && !fifo_pop && (fifo_cnt == FCW'(DATA_LVL - 1));

  always_comb begin
    set_ev          = '0;
    set_ev[IB_COMP] = comp_ev;
    set_ev[IB_DATA] = data_ev;
    set_ev[IB_NACK] = nack_ev;
    set_ev[IB_ROVF] = fifo_ovf && rx;
    set_ev[IB_TOVF] = fifo_ovf && !rx;
    set_ev[IB_RUNF] = fifo_unf;
  end

  i2cm_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(fifo_push), .pop(fifo_pop),
    .wdata(fifo_wdata), .head(fifo_head), .count(fifo_cnt),
    .empty(fifo_empty), .full(fifo_full), .ovf(fifo_ovf), .unf(fifo_unf)
  );

  i2cm_seq #(.CNTW(CNTW), .FCW(FCW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .launch(eng_start), .rx(rx),
    .hold(hold), .host_push(host_push), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .fifo_cnt(fifo_cnt),
    .cnt_wr(bus_wr && (bus_addr == RA_COUNT)),
    .cnt_wdata(bus_wdata[CNTW-1:0]), .eng_done(eng_done),
    .eng_snack(eng_snack), .active(active), .rx_left(rx_left),
    .eng_req(eng_req), .eng_stop(eng_stop), .eng_nack(eng_nack),
    .byte_ok(byte_ok), .comp_ev(comp_ev), .nack_ev(nack_ev)
  );

  i2cm_irq #(.N(NIRQ)) u_irq (
    .clk(clk), .rst(rst), .set_ev(set_ev),
    .clr_wr(bus_wr && (bus_addr == RA_ISTAT)),
    .en_wr(bus_wr && (bus_addr == RA_IEN)),
    .dis_wr(bus_wr && (bus_addr == RA_IDIS)),
    .wdata(bus_wdata), .status(istat), .mask(imask), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      tgt_q     <= '0;
      eng_start <= 1'b0;
      eng_addr  <= '0;
      eng_ten   <= 1'b0;
    end else begin
      eng_start <= start;
      if (wr_ctrl) ctrl_q <= bus_wdata[4:0];
      if (wr_tgt) tgt_q <= bus_wdata;
      if (start) begin
        eng_addr <= ctrl_q[CB_NORMAL] ? {3'b000, bus_wdata[6:0]} : bus_wdata;
        eng_ten  <= !ctrl_q[CB_NORMAL];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        RA_CTRL:   bus_rdata <= REGW'(ctrl_q);
        RA_STAT: begin
          bus_rdata[SB_RXV] <= rx && !fifo_empty;
          bus_rdata[SB_ACT] <= active;
        end
        RA_TARGET: bus_rdata <= tgt_q;
        RA_DATA:   bus_rdata <= (rx && !fifo_empty) ? REGW'(fifo_head) : '0;
        RA_COUNT:  bus_rdata <= rx ? REGW'(rx_left) : REGW'(fifo_cnt);
        RA_ISTAT:  bus_rdata <= istat;
        RA_IEN:    bus_rdata <= imask;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  assert_start_from_write_R2: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(bus_wr && (bus_addr == RA_TARGET)));
  assert_no_start_slave_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_tgt && !ctrl_q[CB_MASTER]) |=> !eng_start);
  assert_last_rx_completes_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_ok && rx && !eng_snack && (rx_left == CNTW'(1))) |=> istat[IB_COMP]);
  assert_underflow_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (host_pop && fifo_empty) |=> istat[IB_RUNF]);
  assert_nack_flag_R12: assert property (@(posedge clk) disable iff (rst)
    (byte_ok && eng_snack) |=> (istat[IB_NACK] && !active));
endmodule

// File: tb/tb_i2cm_xfer_ctl.sv
module tb_i2cm_xfer_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [9:0] bus_wdata = '0;
  logic [9:0] bus_rdata;
  logic       irq, eng_start, eng_ten, eng_rx, eng_req, eng_stop, eng_nack;
  logic [9:0] eng_addr;
  logic [7:0] eng_txd;
  logic       eng_done, eng_snack;
  logic [7:0] eng_rxd;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit eng_pause = 1;
  logic [7:0] txlog [32];
  logic       rx_nk [32];
  int txn = 0, rxn = 0;
  logic [7:0] rx_pat = 8'h40;
  logic tx_st = 0, rx_st = 0;

  always #4 clk = ~clk;

  i2cm_xfer_ctl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .eng_start(eng_start), .eng_addr(eng_addr), .eng_ten(eng_ten),
    .eng_rx(eng_rx), .eng_req(eng_req), .eng_txd(eng_txd),
    .eng_stop(eng_stop), .eng_nack(eng_nack), .eng_done(eng_done),
    .eng_rxd(eng_rxd), .eng_snack(eng_snack)
  );

  // byte engine model: answers a request one clock later
  initial begin
    eng_done = 0;
    eng_rxd  = '0;
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 0;
      else if (eng_req && !eng_pause) begin
        if (eng_rx) begin
          eng_rxd = rx_pat;
          if (rxn < 32) rx_nk[rxn] = eng_nack;
          rx_st = eng_stop;
          rx_pat = rx_pat + 8'd1;
          rxn++;
        end else begin
          if (txn < 32) txlog[txn] = eng_txd;
          tx_st = eng_stop;
          txn++;
        end
        eng_done = 1;
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [9:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [9:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [9:0] exp);
    logic [9:0] v;
    rd(a, v);
    check(req, 16'(v), 16'(exp));
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 4'd0, 10'h000);
    rd_chk("R1 status", 4'd1, 10'h000);
    rd_chk("R1 count", 4'd4, 10'h000);
    rd_chk("R1 istat", 4'd5, 10'h000);
    rd_chk("R1 mask", 4'd6, 10'h000);
    check("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_start;
    eng_pause = 1;
    wr(4'd0, 10'h006);
    wr(4'd2, 10'h3A5);
    check("R2 start pulse", 16'(eng_start), 16'h1);
    check("R2 7-bit addr", 16'(eng_addr), 16'h025);
    check("R2 ten flag", 16'(eng_ten), 16'h0);
    @(negedge clk);
    check("R2 one cycle", 16'(eng_start), 16'h0);
    wr(4'd0, 10'h002);
    wr(4'd2, 10'h3A5);
    check("R2 10-bit addr", 16'(eng_addr), 16'h3A5);
    check("R2 ten set", 16'(eng_ten), 16'h1);
    wr(4'd0, 10'h004);
    wr(4'd2, 10'h011);
    check("R2 no start in slave", 16'(eng_start), 16'h0);
    rd_chk("R13 target readback", 4'd2, 10'h011);
  endtask

  task automatic t_tx;
    eng_pause = 1;
    txn = 0;
    wr(4'd0, 10'h04E);
    wr(4'd5, 10'h3FF);
    for (int k = 0; k < 5; k++) wr(4'd3, 10'(8'h11 + k));
    rd_chk("R3 count=queued", 4'd4, 10'd5);
    wr(4'd2, 10'h050);
    eng_pause = 0;
    repeat (40) @(negedge clk);
    check("R3 byte count", 16'(txn), 16'd5);
    for (int k = 0; k < 5; k++) check("R3 order", 16'(txlog[k]), 16'(8'h11 + k));
    check("R3 stop on last", 16'(tx_st), 16'h1);
    rd_chk("R3 complete", 4'd5, 10'h001);
    rd_chk("R3 bus released", 4'd1, 10'h000);
    rd_chk("R3 count empty", 4'd4, 10'd0);
    wr(4'd5, 10'h001);
    rd_chk("R9 cleared", 4'd5, 10'h000);
  endtask

  task automatic t_ovf;
    eng_pause = 1;
    wr(4'd0, 10'h04E);
    for (int k = 0; k < 17; k++) wr(4'd3, 10'(k));
    rd_chk("R4 count capped", 4'd4, 10'd16);
    rd_chk("R4 tx overflow", 4'd5, 10'h040);
    wr(4'd0, 10'h04E);
    rd_chk("R11 flushed", 4'd4, 10'd0);
    rd_chk("R11 flush reads 0", 4'd0, 10'h00E);
    wr(4'd5, 10'h3FF);
  endtask

  task automatic t_rx;
    logic [9:0] v;
    eng_pause = 1;
    rxn = 0;
    rx_pat = 8'h40;
    wr(4'd0, 10'h05F);
    wr(4'd4, 10'd20);
    wr(4'd5, 10'h3FF);
    wr(4'd2, 10'h050);
    eng_pause = 0;
    repeat (60) @(negedge clk);
    check("R13 stalled at full", 16'(rxn), 16'd16);
    rd_chk("R6 data threshold", 4'd5, 10'h002);
    rd_chk("R5 remaining", 4'd4, 10'd4);
    rd_chk("R7 valid+active", 4'd1, 10'h120);
    for (int k = 0; k < 16; k++) begin
      rd(4'd3, v);
      check("R7 pop order", 16'(v), 16'(8'h40 + k));
    end
    repeat (30) @(negedge clk);
    rd_chk("R5 complete", 4'd5, 10'h003);
    rd_chk("R5 count zero", 4'd4, 10'd0);
    check("R5 nack on last", 16'(rx_nk[19]), 16'h1);
    check("R5 ack before last", 16'(rx_nk[18]), 16'h0);
    check("R8 no stop held", 16'(rx_st), 16'h0);
    rd_chk("R8 bus held", 4'd1, 10'h120);
    for (int k = 0; k < 4; k++) begin
      rd(4'd3, v);
      check("R7 tail order", 16'(v), 16'(8'h50 + k));
    end
    rd_chk("R7 empty read", 4'd3, 10'h000);
    rd_chk("R7 underflow", 4'd5, 10'h083);
    wr(4'd0, 10'h00F);
    rd_chk("R8 released", 4'd1, 10'h000);
  endtask

  task automatic t_irq;
    logic [9:0] v;
    wr(4'd5, 10'h3FF);
    rd(4'd3, v);
    rd_chk("R7 underflow set", 4'd5, 10'h080);
    check("R10 masked off", 16'(irq), 16'h0);
    wr(4'd6, 10'h080);
    check("R10 irq registered", 16'(irq), 16'h0);
    @(negedge clk);
    check("R10 irq on", 16'(irq), 16'h1);
    rd_chk("R10 mask read", 4'd6, 10'h080);
    wr(4'd7, 10'h080);
    @(negedge clk);
    check("R10 irq off", 16'(irq), 16'h0);
    wr(4'd5, 10'h001);
    rd_chk("R9 other bits kept", 4'd5, 10'h080);
    wr(4'd5, 10'h080);
    rd_chk("R9 bit cleared", 4'd5, 10'h000);
  endtask

  task automatic t_snack;
    eng_pause = 1;
    wr(4'd0, 10'h04E);
    wr(4'd5, 10'h3FF);
    for (int k = 0; k < 3; k++) wr(4'd3, 10'(8'hC0 + k));
    wr(4'd2, 10'h021);
    eng_snack = 1;
    eng_pause = 0;
    repeat (10) @(negedge clk);
    eng_pause = 1;
    eng_snack = 0;
    rd_chk("R12 nack no complete", 4'd5, 10'h004);
    rd_chk("R12 bus released", 4'd1, 10'h000);
    rd_chk("R12 remaining queued", 4'd4, 10'd2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    eng_snack = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_start();
    t_tx();
    t_ovf();
    t_rx();
    t_irq();
    t_snack();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule